// File: doc/BRIEF.md
# Five-Channel Event and Timestamp Timer

This block is a small timer peripheral reached through a plain 32-bit read/write strobe bus. It holds four down-counting event channels (A, B, C, D) and one free-running 32-bit up-counter (E) that serves as a timestamp. Software loads an event channel with a count, picks its tick source, chooses one-shot or auto-reload behaviour, and then sets its enable bit. The channel counts selected ticks down to zero and raises an interrupt when it expires. All channel interrupts share one output line.

Ticks come from strobe inputs. A 1 µs strobe is the main timebase, and three alternative strobes can be selected instead. A single packed control word holds each channel's tick selection, its auto-reload bit and its enable bit. Each channel also has a value register. Writing it loads a count, and reading it samples the live count. Channel E only counts once software has chosen a tick source for it, and from then on it can be read at any time as a timestamp.

Top module: `tmr_unit`

## Requirements
- R1: The control word is at byte address 0 and channel t (A=0 … E=4) is at byte address 4×(t+1). Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled. An access whose two low address bits are non-zero is ignored, and such a read returns 0.
- R2: The control word resets to 0. Its fields are: event channel t's tick select at bits [2t+1:2t] (t=0..3), channel E's tick select at bits [10:8], event channel t's auto-reload bit at bit 12+t and its enable bit at bit 16+t. All other bits read as 0.
- R3: Event-channel tick select code 0 picks `tick_us`, and codes 1, 2 and 3 pick `tick_alt[0]`, `tick_alt[1]` and `tick_alt[2]`. Strobes on any other input do not move the channel.
- R4: Writing an event channel's value register loads bits [15:0] into both its live count and its reload store, and bits [31:16] are dropped. A read returns the live count zero-extended to 32 bits. Counts up to 0xFFFE are held exactly.
- R5: An enabled channel loaded with N expires on the (N+1)-th selected tick. `irq` is high for exactly the one cycle after the clock edge that samples that tick.
- R6: In one-shot mode (auto-reload bit 0), expiry clears the channel's enable bit in the control word. The count stays at 0 and no further interrupt follows.
- R7: In auto-reload mode, expiry reloads the stored count and the channel keeps running, so it expires again every N+1 ticks.
- R8: While its enable bit is 0, an event channel's count does not change and the channel raises no interrupt.
- R9: Channel E is a 32-bit up-counter that adds one per selected tick and wraps from 0xFFFFFFFF to 0. Writing it loads the written value. Its select code 1 picks `tick_us`, codes 2, 3 and 4 pick `tick_alt[0..2]`, and every other code (including the reset value 0) stops it.
- R10: `irq` is the OR of all event-channel expiry pulses. Channels that expire on the same tick give a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_us | input | 1 | 1 µs tick strobe |
| tick_alt | input | 3 | Alternative tick strobes |
| irq | output | 1 | Combined expiry interrupt pulse |

## Verification
Event channels are driven with short counts on the 1 µs strobe in one-shot mode, with an alternative strobe in auto-reload mode, and with a large count near 0xFFFE. These patterns separate an off-by-one in the N+1 rule, a wrong tick decode, and a reload that fails or truncates. A channel is paused mid-count and then given more ticks, which shows whether the enable bit truly freezes the count. Two channels are made to expire together to show that they merge into a single pulse. The timestamp is run from several select codes, loaded near its top value to force a wrap, and tested with a misaligned write to confirm that it and the event channels ignore stray accesses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Number of alternative tick strobes reachable through the select codes
  localparam int ALT_N = 3;

  // Tick decode for an event channel: 0 -> 1 us strobe, 1..3 -> alternates
  function automatic logic evt_tick_pick(input logic [1:0] code,
                                         input logic tick_us,
                                         input logic [ALT_N-1:0] alt);
    logic r;
    case (code)
      2'd0:    r = tick_us;
      2'd1:    r = alt[0];
      2'd2:    r = alt[1];
      default: r = alt[2];
    endcase
    return r;
  endfunction

  // Tick decode for the timestamp: 1 -> 1 us, 2..4 -> alternates, else none
  function automatic logic stamp_tick_pick(input logic [2:0] code,
                                           input logic tick_us,
                                           input logic [ALT_N-1:0] alt);
    logic r;
    case (code)
      3'd1:    r = tick_us;
      3'd2:    r = alt[0];
      3'd3:    r = alt[1];
      3'd4:    r = alt[2];
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_evt_chan.sv
module tmr_evt_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire_q,
  output logic             stop_req
);

  logic [CNT_W-1:0] reload_q;
  logic             at_zero;
  logic             fire;

  // Next count on a tick: count down, or on zero reload / park at zero
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] cur,
                                                 input logic [CNT_W-1:0] rel,
                                                 input logic per);
    logic [CNT_W-1:0] r;
    if (cur == '0) r = per ? rel : '0;
    else           r = cur - 1'b1;
    return r;
  endfunction

  assign at_zero  = (count == '0);
  assign fire     = en && tick && at_zero;
  assign stop_req = fire && !periodic;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      reload_q <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= fire;
      if (load) begin
        count    <= load_val;
        reload_q <= load_val;
      end else if (en && tick) begin
        count <= step_down(count, reload_q, periodic);
      end
    end
  end

  // R8
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(count));

  // R8
  expire_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> $past(en));

  // R7
  reload_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && periodic && !load) |=> (count == reload_q));

  // R5
  pulse_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expire_q) |-> ($past(count) == '0));

endmodule

// File: rtl/tmr_stamp_chan.sv
module tmr_stamp_chan #(
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [STAMP_W-1:0] load_val,
  input  logic               tick,
  output logic [STAMP_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (load)   count <= load_val;
    else if (tick)   count <= count + 1'b1;
  end

  // R9
  stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (count == $past(count) + 1'b1));

  // R9
  stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int NUM_EVT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic                       tick_us,
  input  logic [tmr_pkg::ALT_N-1:0]  tick_alt,
  output logic                       irq
);

  import tmr_pkg::*;

  localparam int SEL_W    = 2;
  localparam int ESEL_W   = 3;
  localparam int ESEL_LSB = 8;
  localparam int PER_LSB  = 12;
  localparam int EN_LSB   = 16;
  localparam int WIDX_W   = ADDR_W - 2;
  localparam int STAMP_IX = NUM_EVT + 1;

  logic [NUM_EVT-1:0][SEL_W-1:0] sel_q;
  logic [ESEL_W-1:0]             esel_q;
  logic [NUM_EVT-1:0]            per_q;
  logic [NUM_EVT-1:0]            en_q;

  logic [WIDX_W-1:0]             widx;
  logic                          aligned;
  logic                          ctrl_wr;
  logic [NUM_EVT-1:0]            evt_ld;
  logic                          stamp_ld;
  logic [NUM_EVT-1:0]            evt_tick;
  logic                          stamp_tick;
  logic [NUM_EVT-1:0][CNT_W-1:0] evt_cnt;
  logic [NUM_EVT-1:0]            evt_exp;
  logic [NUM_EVT-1:0]            evt_stop;
  logic [DATA_W-1:0]             stamp_cnt;
  logic [DATA_W-1:0]             ctrl_word;
  logic [DATA_W-1:0]             rd_mux;

  // Bus decode
  assign widx     = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign ctrl_wr  = bus_wr && aligned && (widx == '0);
  assign stamp_ld = bus_wr && aligned && (widx == WIDX_W'(STAMP_IX));

  // Control register: bus write has priority over the hardware enable clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      esel_q <= '0;
      per_q  <= '0;
      en_q   <= '0;
    end else if (ctrl_wr) begin
      for (int i = 0; i < NUM_EVT; i++) begin
        sel_q[i] <= bus_wdata[SEL_W*i +: SEL_W];
        per_q[i] <= bus_wdata[PER_LSB + i];
        en_q[i]  <= bus_wdata[EN_LSB + i];
      end
      esel_q <= bus_wdata[ESEL_LSB +: ESEL_W];
    end else begin
      en_q <= en_q & ~evt_stop;
    end
  end

  always_comb begin
    ctrl_word = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      ctrl_word[SEL_W*i +: SEL_W] = sel_q[i];
      ctrl_word[PER_LSB + i]      = per_q[i];
      ctrl_word[EN_LSB + i]       = en_q[i];
    end
    ctrl_word[ESEL_LSB +: ESEL_W] = esel_q;
  end

  // Event channels
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    assign evt_ld[g]   = bus_wr && aligned && (widx == WIDX_W'(g + 1));
    assign evt_tick[g] = evt_tick_pick(sel_q[g], tick_us, tick_alt);

    tmr_evt_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (evt_ld[g]),
      .load_val (bus_wdata[CNT_W-1:0]),
      .en       (en_q[g]),
      .periodic (per_q[g]),
      .tick     (evt_tick[g]),
      .count    (evt_cnt[g]),
      .expire_q (evt_exp[g]),
      .stop_req (evt_stop[g])
    );

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_stop[g] && !ctrl_wr) |=> !en_q[g]);
  end

  // Timestamp channel
  assign stamp_tick = stamp_tick_pick(esel_q, tick_us, tick_alt);

  tmr_stamp_chan #(.STAMP_W(DATA_W)) u_stamp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (stamp_ld),
    .load_val (bus_wdata),
    .tick     (stamp_tick),
    .count    (stamp_cnt)
  );

  // Read path, registered
  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (widx == '0) rd_mux = ctrl_word;
      if (widx == WIDX_W'(STAMP_IX)) rd_mux = stamp_cnt;
      for (int i = 0; i < NUM_EVT; i++)
        if (widx == WIDX_W'(i + 1)) rd_mux = DATA_W'(evt_cnt[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq = |evt_exp;

  // R2
  ctrl_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[11] == 1'b0) && (ctrl_word[DATA_W-1:EN_LSB+NUM_EVT] == '0));

  // R1
  misaligned_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !aligned) |=> (bus_rdata == '0));

endmodule

// File: tb/tmr_unit_tb.sv
`timescale 1ns/1ps
module tmr_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_us = 1'b0;
  logic [2:0]  tick_alt = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_us(tick_us), .tick_alt(tick_alt), .irq(irq)
  );

  localparam logic [4:0] A_CTRL = 5'd0;
  localparam logic [4:0] A_A = 5'd4, A_B = 5'd8, A_C = 5'd12, A_D = 5'd16, A_E = 5'd20;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // src: 0 = tick_us, 1..3 = tick_alt[src-1]; returns irq seen after the edge
  task automatic pulse(input int src, output logic seen);
    @(negedge clk);
    if (src == 0) tick_us = 1'b1; else tick_alt[src-1] = 1'b1;
    @(negedge clk);
    seen = irq;
    tick_us = 1'b0; tick_alt = '0;
  endtask

  task automatic idle_irq(input string req);
    @(negedge clk);
    check(irq == 1'b0, req, {31'b0, irq}, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic s;
    rd(A_CTRL, d); check(d == 32'h0, "R2 ctrl reset", d, 32'h0);
    rd(A_A, d);    check(d == 32'h0, "R4 count reset", d, 32'h0);
    check(irq == 1'b0, "R5 irq reset", {31'b0, irq}, 32'h0);
    pulse(0, s); pulse(0, s);
    rd(A_E, d);    check(d == 32'h0, "R9 stamp stopped at code 0", d, 32'h0);
  endtask

  task automatic t_ctrl_bits();
    logic [31:0] d;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); check(d == 32'h000F_F7FF, "R2 spare bits zero", d, 32'h000F_F7FF);
    wr(A_CTRL, 32'h0);
    wr(A_A, 32'h0);
    wr(A_B, 32'h0);
    wr(A_C, 32'h0);
    wr(A_D, 32'h0);
    wr(A_E, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    logic s;
    wr(A_A, 32'd3);
    wr(A_CTRL, 32'h0001_0000);
    for (int i = 1; i <= 3; i++) begin
      pulse(0, s); check(s == 1'b0, "R5 no early expiry", {31'b0, s}, 32'h0);
    end
    pulse(0, s); check(s == 1'b1, "R5 expiry on tick N+1", {31'b0, s}, 32'h1);
    idle_irq("R5 irq one cycle");
    rd(A_CTRL, d); check(d == 32'h0, "R6 enable cleared", d, 32'h0);
    pulse(0, s); check(s == 1'b0, "R6 no second irq", {31'b0, s}, 32'h0);
    rd(A_A, d); check(d == 32'h0, "R6 count parked at zero", d, 32'h0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    logic s;
    wr(A_B, 32'd2);
    wr(A_CTRL, 32'h0002_2004);
    for (int i = 1; i <= 6; i++) begin
      pulse(1, s);
      check(s == ((i % 3) == 0), "R7 periodic expiry", {31'b0, s}, {31'b0, ((i % 3) == 0)});
    end
    pulse(0, s); check(s == 1'b0, "R3 other strobe ignored irq", {31'b0, s}, 32'h0);
    rd(A_B, d); check(d == 32'd2, "R3 other strobe ignored count", d, 32'd2);
    rd(A_CTRL, d); check(d == 32'h0002_2004, "R7 enable kept", d, 32'h0002_2004);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_freeze();
    logic [31:0] d;
    logic s;
    wr(A_C, 32'd10);
    wr(A_CTRL, 32'h0004_0000);
    for (int i = 0; i < 3; i++) pulse(0, s);
    rd(A_C, d); check(d == 32'd7, "R4 live count", d, 32'd7);
    wr(A_CTRL, 32'h0);
    for (int i = 0; i < 12; i++) begin
      pulse(0, s); check(s == 1'b0, "R8 no irq when off", {31'b0, s}, 32'h0);
    end
    rd(A_C, d); check(d == 32'd7, "R8 count frozen", d, 32'd7);
  endtask

  task automatic t_wide();
    logic [31:0] d;
    logic s;
    wr(A_D, 32'h0001_FFFE);
    rd(A_D, d); check(d == 32'h0000_FFFE, "R4 upper bits dropped", d, 32'h0000_FFFE);
    wr(A_CTRL, 32'h0008_00C0);
    pulse(3, s);
    rd(A_D, d); check(d == 32'h0000_FFFD, "R4 large count steps", d, 32'h0000_FFFD);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_merge();
    logic [31:0] d;
    logic s;
    wr(A_A, 32'd1);
    wr(A_C, 32'd1);
    wr(A_CTRL, 32'h0005_0000);
    pulse(0, s); check(s == 1'b0, "R10 no early irq", {31'b0, s}, 32'h0);
    pulse(0, s); check(s == 1'b1, "R10 merged irq", {31'b0, s}, 32'h1);
    idle_irq("R10 merged pulse one cycle");
    rd(A_CTRL, d); check(d == 32'h0, "R6 both enables cleared", d, 32'h0);
  endtask

  task automatic t_stamp();
    logic [31:0] d;
    logic s;
    wr(A_CTRL, 32'h0000_0100);
    for (int i = 0; i < 5; i++) pulse(0, s);
    rd(A_E, d); check(d == 32'd5, "R9 stamp counts 1us", d, 32'd5);
    wr(A_E, 32'hFFFF_FFFF);
    pulse(0, s);
    rd(A_E, d); check(d == 32'h0, "R9 stamp wraps", d, 32'h0);
    wr(A_CTRL, 32'h0000_0300);
    pulse(2, s); pulse(2, s); pulse(0, s);
    rd(A_E, d); check(d == 32'd2, "R9 stamp on alternate 1", d, 32'd2);
    wr(A_CTRL, 32'h0000_0700);
    pulse(0, s); pulse(1, s);
    rd(A_E, d); check(d == 32'd2, "R9 stamp stopped code 7", d, 32'd2);
  endtask

  task automatic t_misaligned();
    logic [31:0] d;
    wr(A_E, 32'h0000_1234);
    wr(5'd21, 32'h0000_0077);
    rd(A_E, d); check(d == 32'h0000_1234, "R1 misaligned write ignored", d, 32'h0000_1234);
    rd(5'd22, d); check(d == 32'h0, "R1 misaligned read zero", d, 32'h0);
    wr(A_A, 32'h0000_0009);
    rd(A_A, d); check(d == 32'h9, "R1 channel A address", d, 32'h9);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_bits();
    t_oneshot();
    t_periodic();
    t_freeze();
    t_wide();
    t_merge();
    t_stamp();
    t_misaligned();
    finish_up();
  end

endmodule